// File: doc/BRIEF.md
# Serial Link Out-of-Band Reset/Init Burst Detector

This block watches a per-clock line-activity flag from a squelch circuit on a serial storage link. The flag is high while a signalling burst is on the wire and low while the line idles. The block tells a reset or initialisation request apart from noise. It measures each high run and each low run with counters. A valid request is four bursts in a row, with every idle gap between them inside a minimum/maximum window. When the fourth such burst ends, the block raises a one-cycle detect pulse and a level flag. When the line then stays quiet for longer than the quiet limit, the block raises a one-cycle negation pulse and drops the level.

Every time limit is a parameter in nanoseconds. Each one becomes a cycle count at elaboration, as ceil(ns * CLK_MHZ / 1000). With the default 150 MHz clock, the gap window is 27..79 cycles, the quiet limit is 79 cycles and the glitch limit is 6 cycles. A high run shorter than the glitch limit is dropped. Its cycles count neither as a burst nor as idle time.

Top module: `oob_burst_detector`

## Requirements
- R1: While reset is high and in the first cycle after it, `oob_detect`, `oob_present` and `oob_negate` are all low.
- R2: A train of four bursts of at least 6 cycles each, with every gap between them between 27 and 79 cycles, gives exactly one `oob_detect` pulse one cycle wide, a few cycles after the fourth burst ends.
- R3: Three valid bursts followed by a long quiet give no `oob_detect` pulse.
- R4: The gap window is inclusive at both ends. A gap is the number of cycles `line_active` is low between two bursts. Gaps of exactly 27 and exactly 79 cycles are both accepted.
- R5: A gap shorter than 27 cycles restarts the count, with the burst that ends it counted as the first burst of a new train.
- R6: When the line stays low for more than 79 cycles, the burst count clears. The next burst then counts as the first.
- R7: A high run shorter than 6 cycles is ignored, and its cycles are not added to the gap. A high run of exactly 6 cycles counts as a burst.
- R8: `oob_present` rises in the same cycle as the `oob_detect` pulse and stays high until negation.
- R9: With `oob_present` high, once the line has been low for more than 79 cycles, `oob_negate` pulses for one cycle and `oob_present` falls in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_active | input | 1 | Squelch activity flag, high while a burst is present |
| oob_detect | output | 1 | One-cycle pulse when a valid four-burst train completes |
| oob_present | output | 1 | High from detection until negation |
| oob_negate | output | 1 | One-cycle pulse when quiet after a detection exceeds the limit |

## Verification
The hardest case to reach is a short glitch inside an idle gap. The glitch must neither end the gap nor lengthen it. Checking this needs gap lengths that fall on opposite sides of the 27-cycle minimum depending on whether the glitch cycles are counted. The stimulus therefore places a 5-cycle glitch between two 12-cycle idle stretches. Counted correctly, that gap is 24 cycles and too short; with the glitch counted it would be 29 and valid. The boundary gaps of 26, 27, 79 and 80 cycles are driven cycle-exactly in the same way. Each case uses a scoreboard queue of expected pulses.

// File: rtl/oob_pkg.sv
package oob_pkg;

  // Event bundle passed from the run meter to the train checker
  typedef struct packed {
    logic burst;      // a qualified burst ended this cycle
    logic gap_short;  // idle length before that burst under the window
    logic gap_over;   // idle length beyond the window maximum
    logic quiet;      // idle length beyond the quiet limit
  } oob_evt_t;

  // Round a nanosecond limit up to whole clock cycles
  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/oob_run_meter.sv
module oob_run_meter
  import oob_pkg::*;
#(
  parameter int BURST_MIN_CYC = 6,
  parameter int GAP_MIN_CYC   = 27,
  parameter int GAP_MAX_CYC   = 79,
  parameter int QUIET_CYC     = 79
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     act,
  output oob_evt_t evt
);

  localparam int LIM = ((GAP_MAX_CYC > QUIET_CYC) ? GAP_MAX_CYC : QUIET_CYC) + 1;
  localparam int CW  = $clog2(LIM + 1);
  localparam int HW  = $clog2(BURST_MIN_CYC + 1);
  localparam logic [CW-1:0] LIM_V   = CW'(LIM);
  localparam logic [CW-1:0] GMIN_V  = CW'(GAP_MIN_CYC);
  localparam logic [CW-1:0] GMAX_V  = CW'(GAP_MAX_CYC);
  localparam logic [CW-1:0] QUIET_V = CW'(QUIET_CYC);
  localparam logic [HW-1:0] BMIN_V  = HW'(BURST_MIN_CYC);

  logic [HW-1:0] hi_cnt;
  logic [CW-1:0] gap_cnt;
  logic          run_end, run_long;

  assign run_end  = !act && (hi_cnt != '0);
  assign run_long = (hi_cnt == BMIN_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt  <= '0;
      gap_cnt <= LIM_V;
    end else begin
      if (act) begin
        if (hi_cnt != BMIN_V) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
      if (run_end && run_long)
        gap_cnt <= CW'(1);
      else if (!act && gap_cnt != LIM_V)
        gap_cnt <= gap_cnt + 1'b1;
    end
  end

  always_comb begin
    evt.burst     = run_end && run_long;
    evt.gap_short = gap_cnt < GMIN_V;
    evt.gap_over  = gap_cnt > GMAX_V;
    evt.quiet     = gap_cnt > QUIET_V;
  end

  // R6: idle counter never runs past its saturation value
  a_r6_gap_bounded: assert property (@(posedge clk) disable iff (rst)
    gap_cnt <= LIM_V);

  // R7: a qualified burst end is always preceded by line activity
  a_r7_burst_after_high: assert property (@(posedge clk) disable iff (rst)
    evt.burst |-> $past(act));

endmodule

// File: rtl/oob_train_check.sv
module oob_train_check
  import oob_pkg::*;
#(
  parameter int NEED = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  oob_evt_t evt,
  output logic     det,
  output logic     present,
  output logic     neg
);

  localparam int NW = $clog2(NEED + 1);
  localparam logic [NW-1:0] NEED_V = NW'(NEED);
  localparam logic [NW-1:0] LAST_V = NW'(NEED - 1);

  logic [NW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      det     <= 1'b0;
      present <= 1'b0;
      neg     <= 1'b0;
    end else begin
      det <= 1'b0;
      neg <= 1'b0;
      if (evt.burst) begin
        if (cnt == '0 || evt.gap_short || evt.gap_over) begin
          cnt <= NW'(1);
        end else if (cnt != NEED_V) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_V) begin
            det     <= 1'b1;
            present <= 1'b1;
          end
        end
      end else if (evt.gap_over && cnt != '0) begin
        cnt <= '0;
      end
      if (present && evt.quiet && !evt.burst) begin
        present <= 1'b0;
        neg     <= 1'b1;
      end
    end
  end

  // R2: detect is a single-cycle pulse
  a_r2_detect_one_cycle: assert property (@(posedge clk) disable iff (rst)
    det |=> !det);

  // R8: the level only rises together with a detect pulse
  a_r8_level_rises_with_detect: assert property (@(posedge clk) disable iff (rst)
    $rose(present) |-> det);

  // R9: negation pulse coincides with the level falling
  a_r9_negate_drops_level: assert property (@(posedge clk) disable iff (rst)
    neg |-> (!present && $past(present)));

  // R9: detection and negation never coincide
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(det && neg));

endmodule

// File: rtl/oob_burst_detector.sv
module oob_burst_detector
  import oob_pkg::*;
#(
  parameter int CLK_MHZ      = 150,
  parameter int BURST_MIN_NS = 40,
  parameter int GAP_MIN_NS   = 175,
  parameter int GAP_MAX_NS   = 525,
  parameter int QUIET_NS     = 525,
  parameter int BURSTS       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_active,
  output logic oob_detect,
  output logic oob_present,
  output logic oob_negate
);

  localparam int BMIN_C  = ns_to_cyc(BURST_MIN_NS, CLK_MHZ);
  localparam int GMIN_C  = ns_to_cyc(GAP_MIN_NS, CLK_MHZ);
  localparam int GMAX_C  = ns_to_cyc(GAP_MAX_NS, CLK_MHZ);
  localparam int QUIET_C = ns_to_cyc(QUIET_NS, CLK_MHZ);

  logic     act_q;
  oob_evt_t evt;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= line_active;
  end

  oob_run_meter #(
    .BURST_MIN_CYC(BMIN_C),
    .GAP_MIN_CYC  (GMIN_C),
    .GAP_MAX_CYC  (GMAX_C),
    .QUIET_CYC    (QUIET_C)
  ) u_meter (
    .clk(clk),
    .rst(rst),
    .act(act_q),
    .evt(evt)
  );

  oob_train_check #(
    .NEED(BURSTS)
  ) u_check (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .det    (oob_detect),
    .present(oob_present),
    .neg    (oob_negate)
  );

  // R1: outputs quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!oob_detect && !oob_present && !oob_negate));

endmodule

// File: tb/oob_burst_detector_tb.sv
module oob_burst_detector_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_active = 1'b0;
  wire  oob_detect, oob_present, oob_negate;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  localparam int EV_DET = 1;
  localparam int EV_NEG = 2;

  always #5 clk = ~clk;

  oob_burst_detector u_dut (
    .clk(clk), .rst(rst), .line_active(line_active),
    .oob_detect(oob_detect), .oob_present(oob_present), .oob_negate(oob_negate)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every pulse seen
  always @(negedge clk) begin
    if (!rst) begin
      if (oob_detect) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected detect", EV_DET, 0);
        else begin
          automatic int e = exp_q.pop_front();
          chk(e == EV_DET, "R2 detect order", EV_DET, e);
        end
      end
      if (oob_negate) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected negate", EV_NEG, 0);
        else begin
          automatic int e = exp_q.pop_front();
          chk(e == EV_NEG, "R9 negate order", EV_NEG, e);
        end
      end
    end
  end

  task automatic burst(input int n);
    line_active = 1'b1;
    repeat (n) @(negedge clk);
    line_active = 1'b0;
  endtask

  task automatic idle(input int n);
    line_active = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic train(input int nb, input int gap, input int blen);
    for (int i = 0; i < nb; i++) begin
      burst(blen);
      if (i < nb - 1) idle(gap);
    end
  endtask

  // Closes a case: level shortly after the last burst, then after a long quiet
  task automatic finish_case(input string req, input bit exp_det);
    idle(5);
    chk(oob_present == exp_det, {req, " level after train (R8)"}, oob_present, exp_det);
    idle(100);
    chk(exp_q.size() == 0, {req, " pending pulses"}, exp_q.size(), 0);
    chk(oob_present == 1'b0, {req, " level after quiet (R9)"}, oob_present, 0);
  endtask

  task automatic expect_pair();
    exp_q.push_back(EV_DET);
    exp_q.push_back(EV_NEG);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!oob_detect && !oob_present && !oob_negate, "R1 during reset",
        {oob_detect, oob_present, oob_negate}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!oob_detect && !oob_present && !oob_negate, "R1 after reset",
        {oob_detect, oob_present, oob_negate}, 0);
    idle(10);

    // R2 / R8 / R9: nominal train
    expect_pair();
    train(4, 48, 16);
    finish_case("R2", 1'b1);

    // R3: three bursts only
    train(3, 48, 16);
    finish_case("R3", 1'b0);

    // R4: minimum gap 27 accepted
    expect_pair();
    train(4, 27, 16);
    finish_case("R4 min", 1'b1);

    // R4: maximum gap 79 accepted
    expect_pair();
    train(4, 79, 16);
    finish_case("R4 max", 1'b1);

    // R5: gap of 26 breaks the train
    burst(16); idle(48); burst(16); idle(26); burst(16); idle(48); burst(16);
    finish_case("R5 short", 1'b0);

    // R5: after the short gap the closing burst counts as first
    expect_pair();
    burst(16); idle(48); burst(16); idle(26); burst(16); idle(48); burst(16);
    idle(48); burst(16); idle(48); burst(16);
    finish_case("R5 restart", 1'b1);

    // R6: gap of 80 clears the count, then three more reach four
    burst(16); idle(80); burst(16); idle(48); burst(16); idle(48); burst(16);
    idle(5);
    chk(oob_present == 1'b0, "R6 no detect after break", oob_present, 0);
    expect_pair();
    idle(43); burst(16);
    finish_case("R6", 1'b1);

    // R7: glitches alone never form a train
    train(4, 48, 5);
    finish_case("R7 glitches", 1'b0);

    // R7: burst of exactly the minimum length qualifies
    expect_pair();
    train(4, 48, 6);
    finish_case("R7 min burst", 1'b1);

    // R7: a glitch inside a gap neither ends nor lengthens it
    expect_pair();
    for (int i = 0; i < 3; i++) begin
      burst(16); idle(20); burst(3); idle(28);
    end
    burst(16);
    finish_case("R7 glitch in gap", 1'b1);

    // R7: glitch cycles excluded, so 12+12 idle is a short gap
    for (int i = 0; i < 3; i++) begin
      burst(16); idle(12); burst(5); idle(12);
    end
    burst(16);
    finish_case("R7 glitch short gap", 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule